// File: doc/BRIEF.md
# Stereo Sample Frame Buffer

This block sits in front of a complex-valued transform engine. It takes a two-channel serial audio stream and fills a frame memory with it. The stream is a data line, a bit clock and a word-select line. All three are oversampled by the system clock. Each channel slot gives one sample word, sent most significant bit first. A completed left/right pair becomes one memory entry of twice the sample width. The left sample goes into the real half and the right sample into the imaginary half, so one complex transform can work on both real channels at once.

When a full frame of pairs has been stored, the block stops taking samples and switches to draining. It streams the entries out in arrival order on a valid/hold interface. After the consumer takes the last entry, it pulses a done flag and returns to filling, starting again at the first memory location. Serial traffic that arrives while draining is thrown away.

Top module: `stereo_frame_buffer`

## Requirements
- R1: During and after reset, `out_valid` and `out_done` are 0 and the block is filling from memory address 0.
- R2: A sample word starts at the first bit-clock rising edge after the word-select level changes. It takes the next SAMPLE_W bits, MSB first. Any further bits in the same slot are ignored.
- R3: A word captured while word-select is low is the left sample. A word captured while it is high is the right sample. The stored entry is {left, right}, with the left sample in bits [2*SAMPLE_W-1:SAMPLE_W] (real half) and the right sample in bits [SAMPLE_W-1:0] (imaginary half).
- R4: An entry is written only when a right sample completes and a left sample has been captured since the last write. A right sample with no preceding left is dropped.
- R5: After PAIRS entries have been written, the block enters draining and raises `out_valid` with the first entry.
- R6: Draining presents the entries from address 0 to PAIRS-1, which is the order in which the pairs arrived.
- R7: While `out_valid` and `out_hold` are both 1, `out_valid` stays 1 and `out_data` does not change on the next cycle. An entry is taken on a cycle where `out_valid` is 1 and `out_hold` is 0.
- R8: While draining, serial input is discarded and the write address does not move. A left sample received during draining is never paired with a right sample after draining ends.
- R9: `out_done` is high for exactly one cycle, on the cycle after the last entry is taken. In that same cycle the block is back in filling and `out_valid` is 0. The next frame is stored from address 0.
- R10: `out_valid` is 0 whenever the block is filling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data taken on its rising edge |
| ser_ws | input | 1 | Word select: 0 = left slot, 1 = right slot |
| ser_dat | input | 1 | Serial sample data, MSB first |
| out_hold | input | 1 | Consumer stall; 1 keeps the current entry presented |
| out_data | output | 2*SAMPLE_W | Drained entry {left, right} |
| out_valid | output | 1 | `out_data` holds a drained entry |
| out_done | output | 1 | One-cycle pulse after the last entry of a frame is taken |

## Verification
The bench builds the block with SAMPLE_W = 16 and PAIRS = 8. Because each frame is only eight pairs, it can run three complete fill/drain rounds. That brings the wrap from the last address back to address 0 within reach, as well as the return to filling and the reuse of the memory by a second and third frame. During the first drain the hold input is forced high, so that junk pairs and an orphan left sample can be sent while the block is draining. The next frame then opens with a lone right sample, and the bench checks that it is dropped. Oversized slots and full-scale sample values check the word framing and the packing into the two halves of each entry.

// File: rtl/stereo_frame_buffer.sv
module stereo_frame_buffer #(
  parameter  int SAMPLE_W = 16,
  parameter  int PAIRS    = 256,
  localparam int WORD_W   = 2 * SAMPLE_W,
  localparam int ADDR_W   = $clog2(PAIRS),
  localparam int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_ws,
  input  logic              ser_dat,
  input  logic              out_hold,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_done
);

  typedef enum logic {ST_FILL, ST_DRAIN} state_t;

  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SAMPLE_W - 1);
  localparam logic [ADDR_W-1:0] WA_LAST  = ADDR_W'(PAIRS - 1);
  localparam logic [ADDR_W:0]   RA_END   = (ADDR_W+1)'(PAIRS);
  localparam logic [ADDR_W:0]   RA_LAST  = (ADDR_W+1)'(PAIRS - 1);

  state_t state;
  logic [2:0] sync_a, sync_b;
  logic bclk_d, ws_prev;
  logic [SAMPLE_W-1:0] shreg, left_q;
  logic [CNT_W-1:0] bit_cnt;
  logic left_ok;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W:0] raddr;
  logic out_last;
  logic [WORD_W-1:0] mem [PAIRS];

  wire flushing = (state == ST_DRAIN);
  wire bit_tick = sync_b[2] & ~bclk_d;
  wire ws_now   = sync_b[1];
  wire bit_now  = sync_b[0];
  wire new_word = (ws_now != ws_prev);
  wire word_done = bit_tick & ~flushing & ~new_word & (bit_cnt == CNT_LAST);
  wire [SAMPLE_W-1:0] word_val = {shreg[SAMPLE_W-2:0], bit_now};
  wire do_write = word_done & ws_now & left_ok;

  wire take     = out_valid & ~out_hold;
  wire can_load = flushing & (raddr != RA_END) & (~out_valid | ~out_hold);
  wire finish   = take & out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      bclk_d <= 1'b0;
    end else begin
      sync_a <= {ser_clk, ser_ws, ser_dat};
      sync_b <= sync_a;
      bclk_d <= sync_b[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      bit_cnt <= CNT_FULL;
      shreg   <= '0;
    end else if (bit_tick) begin
      ws_prev <= ws_now;
      if (flushing) begin
        bit_cnt <= CNT_FULL;
      end else if (new_word) begin
        bit_cnt <= CNT_W'(1);
        shreg   <= word_val;
      end else if (bit_cnt != CNT_FULL) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        shreg   <= word_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      left_ok <= 1'b0;
      waddr   <= '0;
      state   <= ST_FILL;
    end else begin
      if (word_done && !ws_now) begin
        left_q  <= word_val;
        left_ok <= 1'b1;
      end
      if (do_write) begin
        left_ok <= 1'b0;
        if (waddr == WA_LAST) begin
          waddr <= '0;
          state <= ST_DRAIN;
        end else begin
          waddr <= waddr + ADDR_W'(1);
        end
      end
      if (finish) state <= ST_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) mem[waddr] <= {left_q, word_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raddr     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_done  <= 1'b0;
    end else begin
      out_done <= finish;
      if (can_load) begin
        out_data  <= mem[raddr[ADDR_W-1:0]];
        out_valid <= 1'b1;
        out_last  <= (raddr == RA_LAST);
        raddr     <= raddr + (ADDR_W+1)'(1);
      end else if (take) begin
        out_valid <= 1'b0;
      end
      if (finish) raddr <= '0;
    end
  end

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_hold,
  input logic [WORD_W-1:0] out_data,
  input logic              out_done,
  input logic              flushing,
  input logic [ADDR_W-1:0] waddr
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_done); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hold |=> out_valid && $stable(out_data)); // R7
  AST_WADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> $stable(waddr)); // R8
  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(out_valid && !out_hold)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done); // R9
  AST_DONE_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !flushing && !out_valid && waddr == '0); // R9
  AST_IDLE_WHILE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !flushing |-> !out_valid); // R10

endmodule

bind stereo_frame_buffer sfb_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_hold(out_hold),
  .out_data(out_data), .out_done(out_done), .flushing(flushing), .waddr(waddr)
);

// File: tb/stereo_frame_buffer_tb.sv
module stereo_frame_buffer_tb;
  localparam int SW = 16;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_ws = 1'b1, ser_dat = 1'b0, out_hold = 1'b1;
  logic [2*SW-1:0] out_data;
  logic out_valid, out_done;

  int checks = 0, errors = 0, beats = 0, cyc = 0;
  bit force_hold = 1'b1, done_due = 1'b0, was_held = 1'b0, ended = 1'b0;
  logic [2*SW-1:0] held_data;
  logic [2*SW-1:0] exp_q[$];

  always #4 clk = ~clk;

  stereo_frame_buffer #(.SAMPLE_W(SW), .PAIRS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_ws(ser_ws), .ser_dat(ser_dat),
    .out_hold(out_hold), .out_data(out_data), .out_valid(out_valid), .out_done(out_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic send_bit(input logic ws, input logic b);
    @(negedge clk) begin ser_ws = ws; ser_dat = b; ser_clk = 1'b0; end
    @(negedge clk);
    @(negedge clk) ser_clk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_word(input logic ws, input logic [SW-1:0] v, input int extra);
    for (int i = 0; i < SW + extra; i++) send_bit(ws, (i < SW) ? v[SW-1-i] : 1'b1);
  endtask

  task automatic send_pair(input logic [SW-1:0] l, input logic [SW-1:0] r, input int extra, input bit keep);
    if (keep) exp_q.push_back({l, r});
    send_word(1'b0, l, extra);
    send_word(1'b1, r, 0);
  endtask

  // monitor: drives hold, takes entries and scores them
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (done_due) begin
        check(out_done === 1'b1, "R9 done pulse", 32'(out_done), 32'd1);
        done_due = 1'b0;
      end else if (out_done) begin
        check(1'b0, "R9 stray done", 32'(out_done), 32'd0);
      end
      if (was_held) check(out_valid === 1'b1 && out_data === held_data, "R7 held entry", out_data, held_data);
      out_hold = force_hold ? 1'b1 : (cyc % 3 == 1);
      was_held = out_valid && out_hold;
      held_data = out_data;
      if (out_valid && !out_hold) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected entry", out_data, 32'h0);
        end else begin
          logic [2*SW-1:0] e;
          e = exp_q.pop_front();
          check(out_data === e, "R3 R6 entry data", out_data, e);
        end
        beats++;
        if (beats % NP == 0) done_due = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'(beats), 32'(3 * NP));
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(out_valid === 1'b0 && out_done === 1'b0, "R1 reset outputs", {out_valid, out_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 idle after reset", 32'(out_valid), 0);

    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);   // partial slot, never completes (R2)

    // frame 1: hold forced, one oversized left slot (R2)
    for (int i = 0; i < NP; i++)
      send_pair(SW'(16'hA000 + i * 16'h0111), SW'(16'hB000 + i * 16'h0022), (i == 3) ? 2 : 0, 1'b1);
    repeat (8) @(negedge clk);
    check(out_valid === 1'b1, "R5 drain starts", 32'(out_valid), 1);
    check(out_data === 32'hA000B000, "R6 first entry", out_data, 32'hA000B000);

    // junk while draining (R8)
    send_pair(16'hDEAD, 16'hBEEF, 0, 1'b0);
    send_word(1'b0, 16'h1234, 0);
    check(out_data === 32'hA000B000, "R8 junk ignored", out_data, 32'hA000B000);
    force_hold = 1'b0;
    wait (beats == NP);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 back to fill", 32'(out_valid), 0);

    // frame 2: lone right first must be dropped (R4, R8)
    send_word(1'b1, 16'h5555, 0);
    for (int i = 0; i < NP; i++)
      send_pair(SW'(16'h1357 ^ (i << 4)), SW'(16'h2468 + i), 0, 1'b1);
    wait (beats == 2 * NP);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 back to fill 2", 32'(out_valid), 0);

    // frame 3: full-scale values in both halves (R3)
    for (int i = 0; i < NP; i++)
      send_pair((i % 2) ? 16'hFFFF : 16'h8000, (i % 2) ? 16'h0000 : 16'h0001, 0, 1'b1);
    wait (beats == 3 * NP);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 all entries drained", 32'(exp_q.size()), 0);
    check(out_valid === 1'b0 && out_done === 1'b0, "R9 quiet after frame", {out_valid, out_done}, 0);
    finish_run();
  end

endmodule